// File: doc/BRIEF.md
# Microphone privacy data zeroing controller

This block sits in the capture path of one microphone link. A privacy switch drives an asynchronous mic-disable level into the block. When software has enabled the zeroing policy, a programmable delay starts once that level asserts. When the delay has run out, every captured sample is replaced with zeros. Muting ends in the same cycle that the synchronized level drops or that the policy is turned off. Only the sample payload is silenced. The valid/ready handshake passes through untouched, so the sample rate and the framing of the stream do not change.

A small register file gives software several fields: the live switch state, a static force-disable indication supplied from outside, a sticky write-1-to-clear change flag with an interrupt enable, the policy enable and the 16-bit timeout. One interrupt output carries the change event whenever the interrupt enable is set.

Top module: `mic_mute_ctrl`

## Requirements
- R1: The mic-disable input passes through a two-flop synchronizer. Status register (address 0) bit 9 reads the synchronized level, two clock edges after the input changes.
- R2: While the policy is enabled and the synchronized level is 1, sample data is forced to zero starting 1+T clock edges after bit 9 first reads 1. T is the timeout at address 2, counted in clock cycles; T=0 mutes on the cycle after.
- R3: When the synchronized level drops, sample data passes unmodified in that same cycle. If the timeout had not yet expired, no sample is ever zeroed.
- R4: Policy enable is address 1 bit 0. Clearing it while muted restores the data immediately, and the delay counter resets. Setting it again waits a full T+1 cycles before muting.
- R5: The change flag (address 0 bit 8) sets one edge after every change of bit 9, rising or falling, whatever the interrupt enable holds.
- R6: Writing 1 to address 0 bit 8 clears the change flag, and writing 0 has no effect. If a clear and a new change land in the same cycle, the flag stays set.
- R7: irq_o is high exactly when the change flag and the interrupt enable (address 0 bit 0, read/write) are both 1.
- R8: Address 0 bit 10 reads the force_dis_i input. Bits 15:11 and 7:1 read zero. Writes to bits 9 and 10 have no effect.
- R9: m_valid_o equals s_valid_i and s_ready_o equals m_ready_i in every cycle, muted or not.
- R10: After reset every register field reads 0, and the timeout register (address 2) holds a full 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mic_dis_i | input | 1 | Asynchronous mic-disable level from the privacy switch |
| force_dis_i | input | 1 | Static force-disable indication |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 2 | Register address |
| csr_wdata_i | input | 16 | Register write data |
| csr_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Change interrupt |
| s_valid_i | input | 1 | Upstream sample valid |
| s_ready_o | output | 1 | Upstream ready |
| s_data_i | input | 24 | Upstream sample |
| m_valid_o | output | 1 | Downstream sample valid |
| m_ready_i | input | 1 | Downstream ready |
| m_data_o | output | 24 | Downstream sample, zero when muted |

## Verification
Several properties are checked on every cycle. Data must pass unmodified whenever the level is low or the policy is off. The handshake must always pass straight through. The change flag must follow every level change, and it may fall only under a write-1 clear. The interrupt must require the flag. Muting may begin only while the level has been high for at least one cycle. The exact length of the delay for a chosen timeout can only be shown by the bench's scenarios. The same holds for aborting before expiry, restarting after a policy toggle, the set-wins collision and the read-only and reserved fields.

// File: rtl/mute_pkg.sv
package mute_pkg;
  localparam int unsigned CSR_AW = 2;
  localparam int unsigned CSR_DW = 16;

  typedef enum logic [CSR_AW-1:0] {
    ADDR_STATUS  = 2'd0,
    ADDR_POLICY  = 2'd1,
    ADDR_TIMEOUT = 2'd2,
    ADDR_UNUSED  = 2'd3
  } csr_addr_e;

  // status register bit positions
  localparam int unsigned BIT_IE    = 0;
  localparam int unsigned BIT_FLAG  = 8;
  localparam int unsigned BIT_LIVE  = 9;
  localparam int unsigned BIT_FORCE = 10;
endpackage

// File: rtl/mute_sync.sv
module mute_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic change_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= async_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_o;

  assign level_o  = sr_q[STAGES-1];
  assign change_o = level_o ^ prev_q;
endmodule

// File: rtl/mute_timer.sv
module mute_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!arm_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == limit_i) done_q <= 1'b1;
      else                  cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign expired_o = done_q;
endmodule

// File: rtl/mute_csr.sv
module mute_csr
  import mute_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CSR_AW-1:0] addr_i,
  input  logic [CSR_DW-1:0] wdata_i,
  output logic [CSR_DW-1:0] rdata_o,
  input  logic              live_i,
  input  logic              change_i,
  input  logic              force_i,
  output logic              flag_o,
  output logic              ie_o,
  output logic              policy_en_o,
  output logic [TW-1:0]     timeout_o
);
  logic          flag_q, ie_q, en_q;
  logic [TW-1:0] tmo_q;
  logic          wr_status, wr_policy, wr_tmo, clr_flag;

  assign wr_status = we_i && (addr_i == ADDR_STATUS);
  assign wr_policy = we_i && (addr_i == ADDR_POLICY);
  assign wr_tmo    = we_i && (addr_i == ADDR_TIMEOUT);
  assign clr_flag  = wr_status && wdata_i[BIT_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      en_q   <= 1'b0;
      tmo_q  <= '0;
    end else begin
      // a fresh change beats a simultaneous clear
      if (change_i)      flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
      if (wr_status) ie_q  <= wdata_i[BIT_IE];
      if (wr_policy) en_q  <= wdata_i[0];
      if (wr_tmo)    tmo_q <= wdata_i[TW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_STATUS: begin
        rdata_o[BIT_IE]    = ie_q;
        rdata_o[BIT_FLAG]  = flag_q;
        rdata_o[BIT_LIVE]  = live_i;
        rdata_o[BIT_FORCE] = force_i;
      end
      ADDR_POLICY:  rdata_o[0] = en_q;
      ADDR_TIMEOUT: rdata_o[TW-1:0] = tmo_q;
      default:      rdata_o = '0;
    endcase
  end

  assign flag_o      = flag_q;
  assign ie_o        = ie_q;
  assign policy_en_o = en_q;
  assign timeout_o   = tmo_q;
endmodule

// File: rtl/mute_datapath.sv
module mute_datapath #(
  parameter int unsigned DW = 24
) (
  input  logic          mute_i,
  input  logic          s_valid_i,
  output logic          s_ready_o,
  input  logic [DW-1:0] s_data_i,
  output logic          m_valid_o,
  input  logic          m_ready_i,
  output logic [DW-1:0] m_data_o
);
  assign m_valid_o = s_valid_i;
  assign s_ready_o = m_ready_i;
  assign m_data_o  = mute_i ? '0 : s_data_i;
endmodule

// File: rtl/mic_mute_ctrl.sv
module mic_mute_ctrl
  import mute_pkg::*;
#(
  parameter int unsigned DW          = 24,
  parameter int unsigned TW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mic_dis_i,
  input  logic              force_dis_i,
  input  logic              csr_we_i,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic [CSR_DW-1:0] csr_wdata_i,
  output logic [CSR_DW-1:0] csr_rdata_o,
  output logic              irq_o,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DW-1:0]     s_data_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DW-1:0]     m_data_o
);
  logic          live, change, flag, ie, policy_en, expired, armed, mute;
  logic [TW-1:0] timeout;

  mute_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_i  (mic_dis_i),
    .level_o  (live),
    .change_o (change)
  );

  mute_csr #(.TW(TW)) u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (csr_we_i),
    .addr_i      (csr_addr_i),
    .wdata_i     (csr_wdata_i),
    .rdata_o     (csr_rdata_o),
    .live_i      (live),
    .change_i    (change),
    .force_i     (force_dis_i),
    .flag_o      (flag),
    .ie_o        (ie),
    .policy_en_o (policy_en),
    .timeout_o   (timeout)
  );

  assign armed = live && policy_en;

  mute_timer #(.TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (armed),
    .limit_i   (timeout),
    .expired_o (expired)
  );

  // gate with the live condition so release needs no clock edge
  assign mute  = expired && armed;
  assign irq_o = flag && ie;

  mute_datapath #(.DW(DW)) u_dp (
    .mute_i    (mute),
    .s_valid_i (s_valid_i),
    .s_ready_o (s_ready_o),
    .s_data_i  (s_data_i),
    .m_valid_o (m_valid_o),
    .m_ready_i (m_ready_i),
    .m_data_o  (m_data_o)
  );
endmodule

// File: rtl/mic_mute_ctrl_chk.sv
module mic_mute_ctrl_chk
  import mute_pkg::*;
#(
  parameter int unsigned DW = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              live,
  input logic              policy_en,
  input logic              flag,
  input logic              mute,
  input logic              irq_o,
  input logic              csr_we_i,
  input logic [CSR_AW-1:0] csr_addr_i,
  input logic [CSR_DW-1:0] csr_wdata_i,
  input logic              s_valid_i,
  input logic              s_ready_o,
  input logic [DW-1:0]     s_data_i,
  input logic              m_valid_o,
  input logic              m_ready_i,
  input logic [DW-1:0]     m_data_o
);
  assert_mute_needs_held_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mute) |-> $past(live));

  assert_pass_when_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |-> (m_data_o == s_data_i));

  assert_pass_when_policy_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !policy_en |-> (m_data_o == s_data_i));

  assert_flag_follows_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live != $past(live)) |=> flag);

  assert_flag_falls_on_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag) |-> $past(csr_we_i && csr_addr_i == ADDR_STATUS && csr_wdata_i[BIT_FLAG]));

  assert_irq_needs_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag);

  assert_handshake_through_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o == s_valid_i) && (s_ready_o == m_ready_i));
endmodule

bind mic_mute_ctrl mic_mute_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .live        (live),
  .policy_en   (policy_en),
  .flag        (flag),
  .mute        (mute),
  .irq_o       (irq_o),
  .csr_we_i    (csr_we_i),
  .csr_addr_i  (csr_addr_i),
  .csr_wdata_i (csr_wdata_i),
  .s_valid_i   (s_valid_i),
  .s_ready_o   (s_ready_o),
  .s_data_i    (s_data_i),
  .m_valid_o   (m_valid_o),
  .m_ready_i   (m_ready_i),
  .m_data_o    (m_data_o)
);

// File: tb/sim_mic_mute_ctrl.sv
`timescale 1ns/1ps
module sim_mic_mute_ctrl;
  localparam int DW = 24;
  localparam logic [DW-1:0] SAMPLE = 24'hA5C3_17;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mic_dis_i = 1'b0, force_dis_i = 1'b0;
  logic          csr_we_i = 1'b0;
  logic [1:0]    csr_addr_i = 2'd0;
  logic [15:0]   csr_wdata_i = '0, csr_rdata_o;
  logic          irq_o;
  logic          s_valid_i = 1'b1, s_ready_o, m_valid_o, m_ready_i = 1'b1;
  logic [DW-1:0] s_data_i = SAMPLE, m_data_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  mic_mute_ctrl #(.DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mic_dis_i(mic_dis_i), .force_dis_i(force_dis_i),
    .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i),
    .csr_rdata_o(csr_rdata_o), .irq_o(irq_o),
    .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .s_data_i(s_data_i),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_data_o(m_data_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    csr_addr_i = a; csr_wdata_i = d; csr_we_i = 1'b1;
    tick(1);
    csr_we_i = 1'b0; csr_addr_i = 2'd0; csr_wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    csr_addr_i = a; #0.5; d = csr_rdata_o; csr_addr_i = 2'd0;
  endtask

  function automatic logic muted();
    return m_data_o == '0;
  endfunction

  // return line to low and clear flag
  task automatic settle();
    mic_dis_i = 1'b0; tick(4);
    wr(2'd0, 16'h0100);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); check("R10 status", v, 16'h0000);
    rd(2'd1, v); check("R10 policy", v, 16'h0000);
    rd(2'd2, v); check("R10 timeout", v, 16'h0000);
    check("R10 irq", irq_o, 1'b0);
    wr(2'd2, 16'hBEEF);
    rd(2'd2, v); check("R10 timeout full width", v, 16'hBEEF);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_sync_status();
    logic [15:0] v;
    mic_dis_i = 1'b1; tick(1);
    rd(2'd0, v); check("R1 not yet after one edge", v[9], 1'b0);
    tick(1);
    rd(2'd0, v); check("R1 live after two edges", v[9], 1'b1);
    check("R2 no mute with policy off", m_data_o, SAMPLE);
    settle();
  endtask

  task automatic t_delay(input int t);
    wr(2'd2, 16'(t)); wr(2'd1, 16'h0001);
    mic_dis_i = 1'b1; tick(2);
    if (t > 0) begin
      tick(t);
      check("R2 still passing before expiry", muted(), 1'b0);
    end
    tick(1);
    check("R2 muted after T+1", m_data_o, '0);
    mic_dis_i = 1'b0; tick(1);
    check("R3 muted until sync drops", m_data_o, '0);
    tick(1);
    check("R3 released same cycle", m_data_o, SAMPLE);
    wr(2'd1, 16'h0000);
    settle();
  endtask

  task automatic t_abort();
    bit seen = 1'b0;
    wr(2'd2, 16'd10); wr(2'd1, 16'h0001);
    mic_dis_i = 1'b1; tick(6);
    mic_dis_i = 1'b0;
    for (int i = 0; i < 20; i++) begin tick(1); if (muted()) seen = 1'b1; end
    check("R3 aborted timer never mutes", seen, 1'b0);
    wr(2'd1, 16'h0000);
    settle();
  endtask

  task automatic t_policy_off();
    wr(2'd2, 16'd3); wr(2'd1, 16'h0001);
    mic_dis_i = 1'b1; tick(2 + 4);
    check("R4 muted before policy off", m_data_o, '0);
    wr(2'd1, 16'h0000);
    check("R4 released on policy off", m_data_o, SAMPLE);
    wr(2'd1, 16'h0001);
    tick(3);
    check("R4 full delay after re-enable", muted(), 1'b0);
    tick(1);
    check("R4 muted after re-enable delay", m_data_o, '0);
    wr(2'd1, 16'h0000);
    settle();
  endtask

  task automatic t_flag();
    logic [15:0] v;
    mic_dis_i = 1'b1; tick(3);
    rd(2'd0, v); check("R5 flag on rise, ie off", v[8], 1'b1);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R6 write 0 keeps flag", v[8], 1'b1);
    wr(2'd0, 16'h0100);
    rd(2'd0, v); check("R6 write 1 clears flag", v[8], 1'b0);
    mic_dis_i = 1'b0; tick(3);
    rd(2'd0, v); check("R5 flag on fall", v[8], 1'b1);
    mic_dis_i = 1'b1; tick(2);
    wr(2'd0, 16'h0100); // clear lands on the change edge
    rd(2'd0, v); check("R6 set wins over clear", v[8], 1'b1);
    settle();
    rd(2'd0, v); check("R6 cleared after settle", v[8], 1'b0);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(2'd0, 16'h0001);
    check("R7 no irq without flag", irq_o, 1'b0);
    mic_dis_i = 1'b1; tick(3);
    check("R7 irq with flag and ie", irq_o, 1'b1);
    wr(2'd0, 16'h0000);
    check("R7 irq off with ie off", irq_o, 1'b0);
    rd(2'd0, v); check("R7 ie reads 0", v[0], 1'b0);
    wr(2'd0, 16'h0001);
    check("R7 irq back with ie", irq_o, 1'b1);
    wr(2'd0, 16'h0101);
    check("R7 irq off after clear", irq_o, 1'b0);
    wr(2'd0, 16'h0000);
    settle();
  endtask

  task automatic t_readonly();
    logic [15:0] v;
    force_dis_i = 1'b1;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); check("R8 force, ro, reserved", v, 16'h0401);
    force_dis_i = 1'b0;
    rd(2'd0, v); check("R8 force follows input", v, 16'h0001);
    wr(2'd0, 16'h0000);
    rd(2'd3, v); check("R8 unused address", v, 16'h0000);
  endtask

  task automatic t_handshake();
    wr(2'd2, 16'd0); wr(2'd1, 16'h0001);
    mic_dis_i = 1'b1; tick(3);
    m_ready_i = 1'b0; s_valid_i = 1'b0; #0.5;
    check("R9 ready passes while muted", s_ready_o, 1'b0);
    check("R9 valid passes while muted", m_valid_o, 1'b0);
    m_ready_i = 1'b1; s_valid_i = 1'b1; #0.5;
    check("R9 ready/valid high while muted", {s_ready_o, m_valid_o}, 2'b11);
    check("R9 data zero with handshake", m_data_o, '0);
    wr(2'd1, 16'h0000);
    settle();
  endtask

  initial begin
    tick(3); rst_ni = 1'b1; tick(1);
    t_reset();
    t_sync_status();
    t_delay(0);
    t_delay(5);
    t_abort();
    t_policy_off();
    t_flag();
    t_irq();
    t_readonly();
    t_handshake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule